// File: doc/BRIEF.md
# Cascadable Display Column Data Loader

This block is the digital core of a 240-output column driver for a passive dot-matrix panel. While it holds the enable token, it takes one 8-bit byte of pixel data on each shift-clock strobe and writes that byte into a 240-bit line register. A direction input chooses whether the line fills from the low-numbered outputs upward or from the high-numbered outputs downward. After the thirtieth byte it hands the token to the next device in a daisy chain and then stops accepting data.

On the falling edge of the load input, the completed line is copied into an output latch. Each latched bit then becomes a 3-bit drive-level code. The code depends on the bit, the frame polarity input and a display-enable input. Levels are numbered 0 to 5. The first device of a chain has its token input tied low. A load pulse re-arms every device in the chain for the next line.

The enable token has two pins on each side. Which pin acts as the input and which as the output is set by the direction input. Only the pin currently in the output role carries the token. The other output is held high.

Top module: `lcd_col_loader`

## Requirements
- R1: After reset, both enable outputs are high. The device is in standby and ignores bytes until a load pulse. With `disp_on`=1 and `fr`=0, every level field reads 3.
- R2: In the cycle after `load` is sampled high, both enable outputs are high. The byte counter restarts from the first byte.
- R3: With `dir`=1, byte k (counting from 0) writes `din[j]` to the line bit for 0-based output 8k+7-j. Output o's code sits in `lvl[3o+2:3o]`.
- R4: With `dir`=0, byte k writes `din[j]` to the line bit for 0-based output 232-8k+j.
- R5: A byte is captured only in a cycle where all of these hold: `scp` is high, `load` is low, the device is armed and not full, and the selected enable input is low. The selected input is `ena_in` when `dir`=1 and `enb_in` when `dir`=0.
- R6: In the cycle after the 30th byte is captured, the selected enable output goes low. It stays low until the next load pulse, and bytes arriving in that time are ignored.
- R7: The line register is copied to the latch at the edge where `load` is first sampled low after being high. `lvl` shows the new line one cycle later. While `fr` and `disp_on` are steady and no such edge occurs, `lvl` does not change.
- R8: With `disp_on`=1, each output's code is computed from `fr` and its latched bit `d`:
  - `fr`=0, `d`=0 gives 3
  - `fr`=0, `d`=1 gives 5
  - `fr`=1, `d`=0 gives 2
  - `fr`=1, `d`=1 gives 0
- R9: With `disp_on`=0, every field is 5, whatever the data and frame.
- R10: The enable pin in the input role (`ena` when `dir`=1, `enb` when `dir`=0) drives its output high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Fill direction and enable pin role select |
| ena_in | input | 1 | Enable pin A input (token in when dir=1) |
| enb_in | input | 1 | Enable pin B input (token in when dir=0) |
| ena_out | output | 1 | Enable pin A output (token out when dir=0) |
| enb_out | output | 1 | Enable pin B output (token out when dir=1) |
| scp | input | 1 | Shift-clock strobe, one byte per high cycle |
| load | input | 1 | Load pulse; high re-arms, falling edge latches |
| din | input | 8 | Parallel pixel byte, din[0] is the first data line |
| fr | input | 1 | Frame polarity |
| disp_on | input | 1 | Display enable, low forces level 5 |
| lvl | output | 720 | 240 three-bit drive-level codes |

## Verification
A captured byte reaches the line register at the strobe's edge. It becomes visible on `lvl` only one cycle after the edge that first samples `load` low. The token output falls one cycle after the 30th capture, and both enable outputs rise one cycle after `load` is seen high. Changes on `fr` and `disp_on` show on `lvl` within the same cycle. The bench drives inputs on falling clock edges and updates a behavioural model on each rising edge. It compares every port two nanoseconds after that rising edge, so each result is sampled exactly in the cycle it is due. Directed checks recompute chosen output codes from the byte list by index arithmetic alone.

// File: rtl/lcdcol_pkg.sv
package lcdcol_pkg;

    typedef enum logic [2:0] {
        LV0 = 3'd0,
        LV1 = 3'd1,
        LV2 = 3'd2,
        LV3 = 3'd3,
        LV4 = 3'd4,
        LV5 = 3'd5
    } drive_lvl_e;

    typedef struct packed {
        logic load_q;
        logic full;
        logic tok;
    } tok_state_t;

    function automatic drive_lvl_e level_of(logic d, logic frame, logic on);
        drive_lvl_e r;
        if (!on) begin
            r = LV5;
        end else begin
            case ({frame, d})
                2'b00:   r = LV3;
                2'b01:   r = LV5;
                2'b10:   r = LV2;
                default: r = LV0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/lcdcol_token_ctl.sv
module lcdcol_token_ctl
    import lcdcol_pkg::*;
#(
    parameter int NBYTE = 30,
    parameter int CW    = $clog2(NBYTE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          scp,
    input  logic          tok_in,
    output logic          capture,
    output logic [CW-1:0] slot,
    output logic          tok_out,
    output logic          latch_now
);

    tok_state_t    st;
    logic [CW-1:0] cnt;

    assign capture   = scp && !load && !st.full && !tok_in;
    assign latch_now = st.load_q && !load;
    assign slot      = cnt;
    assign tok_out   = st.tok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.load_q <= 1'b0;
            st.full   <= 1'b1;
            st.tok    <= 1'b1;
            cnt       <= '0;
        end else begin
            st.load_q <= load;
            if (load) begin
                st.full <= 1'b0;
                st.tok  <= 1'b1;
                cnt     <= '0;
            end else if (capture) begin
                if (cnt == CW'(NBYTE - 1)) begin
                    st.full <= 1'b1;
                    st.tok  <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lcdcol_line_store.sv
module lcdcol_line_store #(
    parameter int NOUT = 240,
    parameter int BW   = 8,
    parameter int CW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [CW-1:0]   slot,
    input  logic            dir,
    input  logic [BW-1:0]   din,
    input  logic            latch_now,
    output logic [NOUT-1:0] shown
);

    localparam int IW = $clog2(NOUT);

    logic [NOUT-1:0] line;
    logic [IW-1:0]   pos [BW];

    always_comb begin
        for (int j = 0; j < BW; j++) begin
            if (dir)
                pos[j] = IW'(int'(slot) * BW + (BW - 1 - j));
            else
                pos[j] = IW'((NOUT - BW) - int'(slot) * BW + j);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line  <= '0;
            shown <= '0;
        end else begin
            if (latch_now)
                shown <= line;
            if (capture) begin
                for (int j = 0; j < BW; j++)
                    line[pos[j]] <= din[j];
            end
        end
    end

endmodule

// File: rtl/lcdcol_level_enc.sv
module lcdcol_level_enc
    import lcdcol_pkg::*;
#(
    parameter int NOUT = 240
) (
    input  logic [NOUT-1:0]   shown,
    input  logic              fr,
    input  logic              disp_on,
    output logic [3*NOUT-1:0] lvl
);

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        assign lvl[3*i +: 3] = level_of(shown[i], fr, disp_on);
    end

endmodule

// File: rtl/lcd_col_loader.sv
module lcd_col_loader
    import lcdcol_pkg::*;
#(
    parameter int NOUT = 240,
    parameter int BW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir,
    input  logic              ena_in,
    input  logic              enb_in,
    output logic              ena_out,
    output logic              enb_out,
    input  logic              scp,
    input  logic              load,
    input  logic [BW-1:0]     din,
    input  logic              fr,
    input  logic              disp_on,
    output logic [3*NOUT-1:0] lvl
);

    localparam int NBYTE = NOUT / BW;
    localparam int CW    = $clog2(NBYTE + 1);

    logic          tok_in;
    logic          tok_out;
    logic          capture;
    logic          latch_now;
    logic [CW-1:0] slot;
    logic [NOUT-1:0] shown;

    assign tok_in  = dir ? ena_in : enb_in;
    assign ena_out = dir ? 1'b1 : tok_out;
    assign enb_out = dir ? tok_out : 1'b1;

    lcdcol_token_ctl #(.NBYTE(NBYTE), .CW(CW)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .scp       (scp),
        .tok_in    (tok_in),
        .capture   (capture),
        .slot      (slot),
        .tok_out   (tok_out),
        .latch_now (latch_now)
    );

    lcdcol_line_store #(.NOUT(NOUT), .BW(BW), .CW(CW)) u_line (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .slot      (slot),
        .dir       (dir),
        .din       (din),
        .latch_now (latch_now),
        .shown     (shown)
    );

    lcdcol_level_enc #(.NOUT(NOUT)) u_enc (
        .shown   (shown),
        .fr      (fr),
        .disp_on (disp_on),
        .lvl     (lvl)
    );

endmodule

// File: rtl/lcd_col_loader_chk.sv
module lcd_col_loader_chk #(
    parameter int NOUT = 240
) (
    input logic              clk,
    input logic              rst,
    input logic              dir,
    input logic              ena_out,
    input logic              enb_out,
    input logic              scp,
    input logic              load,
    input logic              fr,
    input logic              disp_on,
    input logic [3*NOUT-1:0] lvl
);

    p_rearm_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (ena_out && enb_out));

    p_blank_r9: assert property (@(posedge clk) disable iff (rst)
        !disp_on |-> (lvl == {NOUT{3'd5}}));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$fell(load) |=> (!$stable(fr) || !$stable(disp_on) || $stable(lvl)));

    p_handoff_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(dir) && dir && $fell(enb_out)) |-> $past(scp));

    p_keep_low_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(dir) && dir && !$past(enb_out) && !$past(load)) |-> !enb_out);

endmodule

bind lcd_col_loader lcd_col_loader_chk #(.NOUT(NOUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dir     (dir),
    .ena_out (ena_out),
    .enb_out (enb_out),
    .scp     (scp),
    .load    (load),
    .fr      (fr),
    .disp_on (disp_on),
    .lvl     (lvl)
);

// File: tb/lcd_col_loader_test.sv
`timescale 1ns/1ps
module lcd_col_loader_test;

    localparam int NOUT  = 240;
    localparam int BW    = 8;
    localparam int NBYTE = NOUT / BW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dir = 1'b1;
    logic              ena_in = 1'b0;
    logic              enb_in = 1'b0;
    logic              ena_out, enb_out;
    logic              scp = 1'b0;
    logic              load = 1'b0;
    logic [BW-1:0]     din = '0;
    logic              fr = 1'b0;
    logic              disp_on = 1'b1;
    logic [3*NOUT-1:0] lvl;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    bit m_line  [NOUT];
    bit m_latch [NOUT];
    int m_cnt;
    bit m_full, m_tok, m_loadq;

    logic [7:0] bytes_a [NBYTE];
    logic [7:0] bytes_b [NBYTE];

    always #4 clk = ~clk;

    lcd_col_loader uut (
        .clk(clk), .rst(rst), .dir(dir), .ena_in(ena_in), .enb_in(enb_in),
        .ena_out(ena_out), .enb_out(enb_out), .scp(scp), .load(load),
        .din(din), .fr(fr), .disp_on(disp_on), .lvl(lvl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(int o);
        if (!disp_on) return 5;
        if (!fr) return m_latch[o] ? 5 : 3;
        return m_latch[o] ? 0 : 2;
    endfunction

    // behavioural reference model (R2 R3 R4 R5 R6 R7)
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            foreach (m_line[i]) begin m_line[i] = 0; m_latch[i] = 0; end
            m_cnt = 0; m_full = 1; m_tok = 1; m_loadq = 0;
        end else begin
            bit tin;
            tin = dir ? ena_in : enb_in;
            if (m_loadq && !load) m_latch = m_line;
            if (load) begin
                m_cnt = 0; m_full = 0; m_tok = 1;
            end else if (scp && !m_full && !tin) begin
                for (int j = 0; j < BW; j++) begin
                    if (dir) m_line[m_cnt*8 + 7 - j] = din[j];
                    else     m_line[232 - m_cnt*8 + j] = din[j];
                end
                m_cnt++;
                if (m_cnt == NBYTE) begin m_full = 1; m_tok = 0; end
            end
            m_loadq = load;
        end
    end

    // per-clock comparison (R6 R8 R9 R10)
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            int bad;
            bad = -1;
            chk(ena_out == (dir ? 1'b1 : m_tok), "R10/R6 ena_out", int'(ena_out), int'(dir ? 1'b1 : m_tok));
            chk(enb_out == (dir ? m_tok : 1'b1), "R10/R6 enb_out", int'(enb_out), int'(dir ? m_tok : 1'b1));
            for (int o = 0; o < NOUT; o++)
                if (bad < 0 && int'(lvl[3*o +: 3]) != exp_code(o)) bad = o;
            chk(bad < 0, "R8/R9 level field", bad < 0 ? 0 : int'(lvl[3*bad +: 3]),
                bad < 0 ? 0 : exp_code(bad));
        end
    end

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); din = b; scp = 1'b1;
        @(negedge clk); scp = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        chk(0, "watchdog", cycles, 100000);
        finish_run();
    end

    initial begin
        for (int k = 0; k < NBYTE; k++) begin
            bytes_a[k] = 8'(k * 37 + 5);
            bytes_b[k] = 8'(k * 53 + 11);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(ena_out && enb_out, "R1 enables high", int'({ena_out, enb_out}), 3);
        chk(lvl[2:0] == 3'd3 && lvl[3*239 +: 3] == 3'd3, "R1 level 3", int'(lvl[2:0]), 3);
        // R1/R5: standby ignores bytes before any load
        put_byte(8'hFF);
        put_byte(8'hFF);
        pulse_load();
        chk(lvl[3*7 +: 3] == 3'd3, "R1 standby ignores byte", int'(lvl[3*7 +: 3]), 3);

        // dir=1 line, token input on ena_in
        dir = 1'b1;
        ena_in = 1'b1;
        pulse_load();
        put_byte(8'hFF);   // R5: token input high, ignored
        ena_in = 1'b0;
        for (int k = 0; k < NBYTE; k++) begin
            put_byte(bytes_a[k]);
            if (k % 7 == 3) @(negedge clk);
        end
        chk(enb_out == 1'b0, "R6 token handed on", int'(enb_out), 0);
        put_byte(8'h00);   // R6: ignored while full
        chk(enb_out == 1'b0, "R6 stays low", int'(enb_out), 0);
        pulse_load();
        chk(enb_out == 1'b1, "R2 re-armed", int'(enb_out), 1);
        foreach (bytes_a[k]) begin end
        for (int t = 0; t < 4; t++) begin
            int o, k, j, e;
            o = (t == 0) ? 0 : (t == 1) ? 7 : (t == 2) ? 8 : 239;
            k = o / 8; j = 7 - (o % 8);
            e = bytes_a[k][j] ? 5 : 3;
            chk(int'(lvl[3*o +: 3]) == e, "R3 mapping dir=1", int'(lvl[3*o +: 3]), e);
        end
        // R8: frame polarity
        @(negedge clk); fr = 1'b1;
        @(negedge clk);
        begin
            int e;
            e = bytes_a[0][7] ? 0 : 2;
            chk(int'(lvl[2:0]) == e, "R8 fr high", int'(lvl[2:0]), e);
        end
        // R9: display off
        @(negedge clk); disp_on = 1'b0;
        @(negedge clk);
        chk(lvl == {NOUT{3'd5}}, "R9 forced 5", int'(lvl[2:0]), 5);
        @(negedge clk); disp_on = 1'b1; fr = 1'b0;

        // dir=0 line, token input on enb_in
        dir = 1'b0;
        enb_in = 1'b1;
        ena_in = 1'b1;
        pulse_load();
        put_byte(8'hAA);   // R5: ignored, enb_in high
        enb_in = 1'b0;
        for (int k = 0; k < NBYTE; k++) begin
            if (k == 10) begin
                // R5: load high blocks capture; it also restarts the count (R2)
                @(negedge clk); load = 1'b1; din = 8'h55; scp = 1'b1;
                @(negedge clk); load = 1'b0; scp = 1'b0;
                for (int r = 0; r < 10; r++) put_byte(bytes_b[r]);
            end
            put_byte(bytes_b[k]);
        end
        chk(ena_out == 1'b0, "R6 dir=0 hand-off", int'(ena_out), 0);
        chk(enb_out == 1'b1, "R10 dir=0 idle pin", int'(enb_out), 1);
        pulse_load();
        for (int t = 0; t < 4; t++) begin
            int o, k, j, e;
            o = (t == 0) ? 239 : (t == 1) ? 232 : (t == 2) ? 231 : 0;
            k = (239 - o) / 8; j = o - 232 + 8 * k;
            e = bytes_b[k][j] ? 5 : 3;
            chk(int'(lvl[3*o +: 3]) == e, "R4 mapping dir=0", int'(lvl[3*o +: 3]), e);
        end
        // R7: no new latch without a falling load edge
        put_byte(8'hFF);
        repeat (3) @(negedge clk);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule